// File: doc/BRIEF.md
# BCD Calendar Core with Alarms and Periodic Wakeup

This block keeps wall-clock time and a calendar entirely in binary-coded decimal. A slow enable pulse from a prescaler (`tick_in`) drives a subsecond counter. Each time that counter wraps, one second is added and the carry ripples upward through minutes, hours, weekday, date, month and year. Hours run in 24-hour or 12-hour form; 12-hour form carries an AM/PM flag. The month length comes from the month and the two-digit year, so 28-, 29-, 30- and 31-day months roll over without software help.

A small write port loads the time, the date, two alarm words, the wakeup reload word and a control word. Both alarms are checked once per second, after each update has finished, and each alarm gives a one-cycle event. A free-running down-counter, clocked by the same `tick_in`, gives periodic wakeup events. A pulse on `ts_in` freezes a copy of the time, date and subsecond count.

The carry ripple is a state machine with these states:
- CS_IDLE waits for the subsecond wrap and then moves to CS_SEC.
- CS_SEC, CS_MIN, CS_HOUR, CS_DAY, CS_MONTH and CS_YEAR each update one field. Each moves to the next field state when its field wraps, and to CS_MATCH when it does not. CS_YEAR always moves to CS_MATCH.
- CS_MATCH evaluates both alarms and returns to CS_IDLE.
- A time or date write sends the machine straight to CS_IDLE.

A full ripple takes at most eight clock cycles, so `tick_in` pulses must be at least eight cycles apart.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD, with digit carry (09 to 10) and a carry into the next field when 59 wraps to 00. The time word has seconds in bits 6:0, minutes in bits 14:8, hours in bits 21:16 and PM in bit 22.
- R2: In 24-hour mode (control bit 0 = 0) the hour counts 00 to 23. The wrap from 23 to 00 advances the date, and no other hour change does.
- R3: In 12-hour mode (control bit 0 = 1) the hour runs 12, 01, 02 up to 11. The PM flag (bit 22) toggles only on the step from 11 to 12, and the date advances only on the step from 11 PM to 12 AM. In 24-hour mode, writes clear the PM bit.
- R4: The date wraps to 01 after day 28 or 29 of month 02, after day 30 of months 04, 06, 09 and 11, and after day 31 of all other months. February has 29 days when the binary year is divisible by 4, year 00 included. The date word has the date in bits 5:0, the month in bits 12:8, the year in bits 23:16 and the weekday in bits 26:24.
- R5: The month wraps from 12 to 01 and advances the year, and the year wraps from 99 to 00.
- R6: The weekday counts 1 to 7. It advances once with every date change and wraps from 7 to 1.
- R7: Each alarm word holds:
  - seconds (6:0) with mask bit 7;
  - minutes (14:8) with mask bit 15;
  - hours (21:16) with PM in bit 22 and mask bit 23;
  - day (29:24) with mask bit 31.
  Bit 30 set makes the day field compare against the weekday instead of the date. A masked field always matches, and PM is compared only in 12-hour mode. An enabled alarm (control bit 1 for alarm 0, control bit 2 for alarm 1) gives a one-cycle pulse on `alarm_evt` for every second in which it matches. A disabled alarm gives none.
- R8: Writing the wakeup word loads the reload value from bits WAKE_W-1:0 and the enable from bit WAKE_W. While enabled, `wake_evt` pulses once every reload+1 ticks. When disabled it never pulses.
- R9: A `ts_in` pulse copies the current time word, date word and subsecond count to the `ts_*` outputs. These outputs then hold until the next pulse.
- R10: Reset gives time 00:00:00, date 01, month 01, year 00, weekday 1, 24-hour mode, and alarms and wakeup disabled. A time write clears the subsecond count, and one second is added every SUB_DIV ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | One-cycle prescaler pulse; clocks the subsecond and wakeup counters |
| cfg_wr | input | 1 | Write strobe for the register port |
| cfg_sel | input | 3 | Register select: 0 time, 1 date, 2 alarm 0, 3 alarm 1, 4 wakeup, 5 control |
| cfg_wdata | input | 32 | Write data |
| ts_in | input | 1 | Timestamp capture pulse |
| cur_time | output | 32 | Current time word |
| cur_date | output | 32 | Current date word |
| cur_subsec | output | SS_W | Current subsecond count |
| ts_time | output | 32 | Captured time word |
| ts_date | output | 32 | Captured date word |
| ts_subsec | output | SS_W | Captured subsecond count |
| alarm_evt | output | 2 | One-cycle alarm events, bit g for alarm g |
| wake_evt | output | 1 | One-cycle periodic wakeup event |

## Verification
The bench builds the block with SUB_DIV = 2, so one second costs only two ticks. It keeps WAKE_W at its natural 17 bits. This makes it cheap to sweep every month end for a common year, two leap years (24 and 00) and the 99 to 00 wrap. The same setting lets it walk every hour boundary in both hour formats and count 61 seconds straight through. Alarm masks, weekday matching and wakeup periods are then checked by counting event pulses over known numbers of seconds and ticks.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_SEC,
        CS_MIN,
        CS_HOUR,
        CS_DAY,
        CS_MONTH,
        CS_YEAR,
        CS_MATCH
    } cal_state_e;

    localparam logic [2:0] SEL_TIME  = 3'd0;
    localparam logic [2:0] SEL_DATE  = 3'd1;
    localparam logic [2:0] SEL_ALM_A = 3'd2;
    localparam logic [2:0] SEL_ALM_B = 3'd3;
    localparam logic [2:0] SEL_WAKE  = 3'd4;
    localparam logic [2:0] SEL_CTRL  = 3'd5;

    localparam int N_ALARM = 2;

    // Alarm word: first member is the most significant bit
    typedef struct packed {
        logic       mask_day;
        logic       wd_sel;
        logic [5:0] day;
        logic       mask_hour;
        logic       pm;
        logic [5:0] hour;
        logic       mask_min;
        logic [6:0] min;
        logic       mask_sec;
        logic [6:0] sec;
    } alarm_t;

    // Add one to a two-digit BCD value (no wrap handling)
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last day of a BCD month for a two-digit BCD year
    function automatic logic [5:0] month_days(input logic [4:0] mon, input logic [7:0] yr);
        logic [7:0] ybin;
        logic       leap;
        ybin = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
        leap = (ybin[1:0] == 2'b00);
        case (mon)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_subsec.sv
module cal_subsec #(
    parameter int DIV = 256,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    output logic [W-1:0] count,
    output logic         carry
);

    logic [W-1:0] cnt_q;

    assign carry = tick && (cnt_q == W'(DIV - 1));
    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= carry ? '0 : cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import rtc_cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] word,
    input  logic        enable,
    input  logic        h12,
    input  logic        check,
    input  logic [6:0]  sec,
    input  logic [6:0]  min,
    input  logic [5:0]  hour,
    input  logic        pm,
    input  logic [5:0]  date,
    input  logic [2:0]  wday,
    output logic        hit
);

    alarm_t cfg_q;
    logic   sec_ok, min_ok, hour_ok, day_ok;
    logic   hit_q;

    always_comb begin
        sec_ok  = cfg_q.mask_sec  || (cfg_q.sec == sec);
        min_ok  = cfg_q.mask_min  || (cfg_q.min == min);
        hour_ok = cfg_q.mask_hour || ((cfg_q.hour == hour) && (!h12 || (cfg_q.pm == pm)));
        day_ok  = cfg_q.mask_day  ||
                  (cfg_q.wd_sel ? (cfg_q.day[2:0] == wday) : (cfg_q.day == date));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            hit_q <= 1'b0;
        end else begin
            if (load) begin
                cfg_q <= alarm_t'(word);
            end
            hit_q <= check && enable && sec_ok && min_ok && hour_ok && day_ok;
        end
    end

    assign hit = hit_q;

endmodule

// File: rtl/cal_wakeup.sv
module cal_wakeup #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W:0]   word,
    input  logic         tick,
    output logic         evt,
    output logic [W-1:0] count,
    output logic [W-1:0] reload
);

    logic [W-1:0] reload_q, cnt_q;
    logic         en_q, evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            en_q     <= 1'b0;
            evt_q    <= 1'b0;
        end else if (load) begin
            reload_q <= word[W-1:0];
            cnt_q    <= word[W-1:0];
            en_q     <= word[W];
            evt_q    <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (en_q && tick) begin
                if (cnt_q == '0) begin
                    evt_q <= 1'b1;
                    cnt_q <= reload_q;
                end else begin
                    cnt_q <= cnt_q - W'(1);
                end
            end
        end
    end

    assign evt    = evt_q;
    assign count  = cnt_q;
    assign reload = reload_q;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int SUB_DIV = 256,
    parameter int WAKE_W  = 17,
    parameter int SS_W    = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              ts_in,
    output logic [31:0]       cur_time,
    output logic [31:0]       cur_date,
    output logic [SS_W-1:0]   cur_subsec,
    output logic [31:0]       ts_time,
    output logic [31:0]       ts_date,
    output logic [SS_W-1:0]   ts_subsec,
    output logic [N_ALARM-1:0] alarm_evt,
    output logic              wake_evt
);

    cal_state_e state_q, state_d;

    logic [6:0] sec_q, min_q;
    logic [5:0] hour_q;
    logic       pm_q;
    logic [5:0] date_q;
    logic [4:0] mon_q;
    logic [7:0] year_q;
    logic [2:0] wday_q;
    logic       h12_q;
    logic [N_ALARM-1:0] alm_en_q;

    logic wr_time, wr_date, wr_ctrl, wr_wake;
    logic [N_ALARM-1:0] alm_load;
    logic sec_carry;
    logic [SS_W-1:0] subsec;
    logic [7:0] sec_inc, min_inc, hour_inc, date_inc, mon_inc, year_inc;
    logic [5:0] mdays;
    logic [2:0] wday_nx;
    logic [WAKE_W-1:0] wk_cnt, wk_reload;
    logic hour_step, match_step;

    assign wr_time     = cfg_wr && (cfg_sel == SEL_TIME);
    assign wr_date     = cfg_wr && (cfg_sel == SEL_DATE);
    assign wr_ctrl     = cfg_wr && (cfg_sel == SEL_CTRL);
    assign wr_wake     = cfg_wr && (cfg_sel == SEL_WAKE);
    assign alm_load[0] = cfg_wr && (cfg_sel == SEL_ALM_A);
    assign alm_load[1] = cfg_wr && (cfg_sel == SEL_ALM_B);
    assign hour_step   = (state_q == CS_HOUR);
    assign match_step  = (state_q == CS_MATCH);

    cal_subsec #(.DIV(SUB_DIV), .W(SS_W)) u_sub (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_in),
        .clear (wr_time),
        .count (subsec),
        .carry (sec_carry)
    );

    always_comb begin
        sec_inc  = bcd_inc8({1'b0, sec_q});
        min_inc  = bcd_inc8({1'b0, min_q});
        hour_inc = bcd_inc8({2'b0, hour_q});
        date_inc = bcd_inc8({2'b0, date_q});
        mon_inc  = bcd_inc8({3'b0, mon_q});
        year_inc = bcd_inc8(year_q);
        mdays    = month_days(mon_q, year_q);
        wday_nx  = (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
    end

    // Next-state logic of the carry ripple
    always_comb begin
        state_d = state_q;
        if (wr_time || wr_date) begin
            state_d = CS_IDLE;
        end else begin
            unique case (state_q)
                CS_IDLE:  if (sec_carry) state_d = CS_SEC;
                CS_SEC:   state_d = (sec_q == 7'h59) ? CS_MIN : CS_MATCH;
                CS_MIN:   state_d = (min_q == 7'h59) ? CS_HOUR : CS_MATCH;
                CS_HOUR: begin
                    if (h12_q) state_d = (hour_q == 6'h11 && pm_q) ? CS_DAY : CS_MATCH;
                    else       state_d = (hour_q == 6'h23) ? CS_DAY : CS_MATCH;
                end
                CS_DAY:   state_d = (date_q == mdays) ? CS_MONTH : CS_MATCH;
                CS_MONTH: state_d = (mon_q == 5'h12) ? CS_YEAR : CS_MATCH;
                CS_YEAR:  state_d = CS_MATCH;
                CS_MATCH: state_d = CS_IDLE;
                default:  state_d = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // Calendar field registers, one field per ripple state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= 7'h00;
            min_q  <= 7'h00;
            hour_q <= 6'h00;
            pm_q   <= 1'b0;
            date_q <= 6'h01;
            mon_q  <= 5'h01;
            year_q <= 8'h00;
            wday_q <= 3'd1;
        end else if (wr_time) begin
            sec_q  <= cfg_wdata[6:0];
            min_q  <= cfg_wdata[14:8];
            hour_q <= cfg_wdata[21:16];
            pm_q   <= cfg_wdata[22] & h12_q;
        end else if (wr_date) begin
            date_q <= cfg_wdata[5:0];
            mon_q  <= cfg_wdata[12:8];
            year_q <= cfg_wdata[23:16];
            wday_q <= cfg_wdata[26:24];
        end else begin
            unique case (state_q)
                CS_SEC: sec_q <= (sec_q == 7'h59) ? 7'h00 : sec_inc[6:0];
                CS_MIN: min_q <= (min_q == 7'h59) ? 7'h00 : min_inc[6:0];
                CS_HOUR: begin
                    if (h12_q) begin
                        if (hour_q == 6'h12) begin
                            hour_q <= 6'h01;
                        end else if (hour_q == 6'h11) begin
                            hour_q <= 6'h12;
                            pm_q   <= ~pm_q;
                        end else begin
                            hour_q <= hour_inc[5:0];
                        end
                    end else begin
                        hour_q <= (hour_q == 6'h23) ? 6'h00 : hour_inc[5:0];
                    end
                end
                CS_DAY: begin
                    wday_q <= wday_nx;
                    date_q <= (date_q == mdays) ? 6'h01 : date_inc[5:0];
                end
                CS_MONTH: mon_q  <= (mon_q == 5'h12) ? 5'h01 : mon_inc[4:0];
                CS_YEAR:  year_q <= (year_q == 8'h99) ? 8'h00 : year_inc;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h12_q    <= 1'b0;
            alm_en_q <= '0;
        end else if (wr_ctrl) begin
            h12_q    <= cfg_wdata[0];
            alm_en_q <= cfg_wdata[N_ALARM:1];
        end
    end

    // Output packing
    always_comb begin
        cur_time   = {9'd0, pm_q, hour_q, 1'b0, min_q, 1'b0, sec_q};
        cur_date   = {5'd0, wday_q, year_q, 3'd0, mon_q, 2'd0, date_q};
        cur_subsec = subsec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_time   <= '0;
            ts_date   <= '0;
            ts_subsec <= '0;
        end else if (ts_in) begin
            ts_time   <= cur_time;
            ts_date   <= cur_date;
            ts_subsec <= subsec;
        end
    end

    for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
        cal_alarm u_alm (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (alm_load[g]),
            .word   (cfg_wdata),
            .enable (alm_en_q[g]),
            .h12    (h12_q),
            .check  (match_step),
            .sec    (sec_q),
            .min    (min_q),
            .hour   (hour_q),
            .pm     (pm_q),
            .date   (date_q),
            .wday   (wday_q),
            .hit    (alarm_evt[g])
        );
    end

    cal_wakeup #(.W(WAKE_W)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_wake),
        .word   (cfg_wdata[WAKE_W:0]),
        .tick   (tick_in),
        .evt    (wake_evt),
        .count  (wk_cnt),
        .reload (wk_reload)
    );

endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
    parameter int WAKE_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h12,
    input logic              hour_step,
    input logic [5:0]        hour,
    input logic [6:0]        sec,
    input logic [5:0]        date,
    input logic [1:0]        alarm,
    input logic              wake_evt,
    input logic [WAKE_W-1:0] wk_cnt,
    input logic [WAKE_W-1:0] wk_reload,
    input logic              ts_in,
    input logic [31:0]       ts_time
);

    function automatic logic hour12_ok(input logic [5:0] h);
        return ((h >= 6'h01) && (h <= 6'h09)) || ((h >= 6'h10) && (h <= 6'h12));
    endfunction

    // R1: seconds stay a legal BCD value
    p_sec_bcd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sec[3:0] <= 4'd9) && (sec[6:4] <= 3'd5));

    // R3: a legal 12-hour value stays legal across an hour step
    p_hour12_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h12 && hour_step && hour12_ok(hour)) |=> hour12_ok(hour));

    // R4: date is never zero and never past 31
    p_date_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (date != 6'h00) && (date[3:0] <= 4'd9) && (date <= 6'h31));

    // R7: alarm events are single-cycle pulses
    p_alarm0_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm[0] |=> !alarm[0]);

    p_alarm1_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm[1] |=> !alarm[1]);

    // R8: a wakeup event coincides with a freshly reloaded counter
    p_wake_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> (wk_cnt == wk_reload));

    // R9: captured time only changes on a capture pulse
    p_ts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_in |=> $stable(ts_time));

endmodule

bind rtc_calendar cal_checker #(.WAKE_W(WAKE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .h12       (h12_q),
    .hour_step (hour_step),
    .hour      (hour_q),
    .sec       (sec_q),
    .date      (date_q),
    .alarm     (alarm_evt),
    .wake_evt  (wake_evt),
    .wk_cnt    (wk_cnt),
    .wk_reload (wk_reload),
    .ts_in     (ts_in),
    .ts_time   (ts_time)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;

    localparam int CLK_PERIOD = 10;
    localparam int SUB_DIV    = 2;
    localparam int WAKE_W     = 17;
    localparam int SS_W       = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_in = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [2:0]        cfg_sel = 3'd0;
    logic [31:0]       cfg_wdata = 32'd0;
    logic              ts_in = 1'b0;
    logic [31:0]       cur_time, cur_date, ts_time, ts_date;
    logic [SS_W-1:0]   cur_subsec, ts_subsec;
    logic [1:0]        alarm_evt;
    logic              wake_evt;

    int n_chk  = 0;
    int n_fail = 0;
    int cnt_a  = 0;
    int cnt_b  = 0;
    int cnt_w  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_calendar #(.SUB_DIV(SUB_DIV), .WAKE_W(WAKE_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ts_in      (ts_in),
        .cur_time   (cur_time),
        .cur_date   (cur_date),
        .cur_subsec (cur_subsec),
        .ts_time    (ts_time),
        .ts_date    (ts_date),
        .ts_subsec  (ts_subsec),
        .alarm_evt  (alarm_evt),
        .wake_evt   (wake_evt)
    );

    always @(posedge clk) begin
        if (alarm_evt[0]) cnt_a <= cnt_a + 1;
        if (alarm_evt[1]) cnt_b <= cnt_b + 1;
        if (wake_evt)     cnt_w <= cnt_w + 1;
    end

    function automatic logic [7:0] bcd8(input int v);
        return 8'(((v / 10) << 4) + (v % 10));
    endfunction

    function automatic logic [31:0] tword(input int h, input int m, input int s, input bit pm);
        logic [7:0] bh, bm, bs;
        bh = bcd8(h); bm = bcd8(m); bs = bcd8(s);
        return {9'd0, pm, bh[5:0], 1'b0, bm[6:0], 1'b0, bs[6:0]};
    endfunction

    function automatic logic [31:0] dword(input int d, input int mo, input int y, input int w);
        logic [7:0] bd, bm, by;
        bd = bcd8(d); bm = bcd8(mo); by = bcd8(y);
        return {5'd0, 3'(w), by, 3'd0, bm[4:0], 2'd0, bd[5:0]};
    endfunction

    function automatic int days_in(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic adv_sec(input int n);
        for (int i = 0; i < n * SUB_DIV; i++) tick_once();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base_a, base_b, base_w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 reset time", cur_time, 32'h0);
        check("R10 reset date", cur_date, 32'h0100_0101);
        check("R10 reset events", {29'd0, alarm_evt, wake_evt}, 32'h0);

        // R10: subsecond prescale and clear on time write
        write_reg(SEL_TIME_C, tword(1, 2, 3, 0));
        check("R10 subsec cleared", 32'(cur_subsec), 32'd0);
        tick_once();
        check("R10 subsec one", 32'(cur_subsec), 32'd1);
        check("R10 no second yet", cur_time, tword(1, 2, 3, 0));
        tick_once();
        check("R10 second after SUB_DIV", cur_time, tword(1, 2, 4, 0));

        // R1: 61 straight seconds
        write_reg(SEL_TIME_C, tword(0, 0, 0, 0));
        for (int i = 1; i <= 61; i++) begin
            adv_sec(1);
            check("R1 seconds sweep", cur_time, tword(0, i / 60, i % 60, 0));
        end
        write_reg(SEL_TIME_C, tword(10, 9, 59, 0));
        adv_sec(1);
        check("R1 minute digit carry", cur_time, tword(10, 10, 0, 0));

        // R2: 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            write_reg(SEL_TIME_C, tword(h, 59, 59, 0));
            write_reg(SEL_DATE_C, dword(15, 6, 24, 3));
            adv_sec(1);
            check("R2 hour step", cur_time, tword((h + 1) % 24, 0, 0, 0));
            check("R2 date step", cur_date, (h == 23) ? dword(16, 6, 24, 4) : dword(15, 6, 24, 3));
        end

        // R3: 12-hour sweep
        write_reg(SEL_CTRL_C, 32'h1);
        for (int p = 0; p < 2; p++) begin
            for (int h = 1; h <= 12; h++) begin
                write_reg(SEL_TIME_C, tword(h, 59, 59, p[0]));
                write_reg(SEL_DATE_C, dword(15, 6, 24, 3));
                adv_sec(1);
                check("R3 hour12 step", cur_time,
                      tword((h == 12) ? 1 : h + 1, 0, 0, (h == 11) ? !p[0] : p[0]));
                check("R3 date at midnight", cur_date,
                      (h == 11 && p == 1) ? dword(16, 6, 24, 4) : dword(15, 6, 24, 3));
            end
        end
        write_reg(SEL_CTRL_C, 32'h0);

        // R4 R5 R6: month ends over several years
        for (int yi = 0; yi < 4; yi++) begin
            int y;
            y = (yi == 0) ? 23 : (yi == 1) ? 24 : (yi == 2) ? 0 : 99;
            for (int m = 1; m <= 12; m++) begin
                int len, w;
                len = days_in(m, y);
                w   = (m % 7) + 1;
                write_reg(SEL_TIME_C, tword(23, 59, 59, 0));
                write_reg(SEL_DATE_C, dword(len - 1, m, y, w));
                adv_sec(1);
                check("R4 day before end", cur_date, dword(len, m, y, (w == 7) ? 1 : w + 1));
                write_reg(SEL_TIME_C, tword(23, 59, 59, 0));
                write_reg(SEL_DATE_C, dword(len, m, y, w));
                adv_sec(1);
                check("R4 R5 R6 month end", cur_date,
                      dword(1, (m == 12) ? 1 : m + 1, (m == 12) ? (y + 1) % 100 : y,
                            (w == 7) ? 1 : w + 1));
                check("R2 midnight time", cur_time, tword(0, 0, 0, 0));
            end
        end

        // R7: alarms
        write_reg(SEL_TIME_C, tword(12, 0, 0, 0));
        write_reg(SEL_DATE_C, dword(1, 1, 24, 1));
        write_reg(SEL_ALM_A_C, {1'b0, 1'b0, 6'h01, 1'b0, 1'b0, 6'h12, 1'b0, 7'h00, 1'b0, 7'h05});
        write_reg(SEL_ALM_B_C, {1'b1, 1'b0, 6'h00, 1'b1, 1'b0, 6'h00, 1'b1, 7'h00, 1'b0, 7'h03});
        write_reg(SEL_CTRL_C, 32'h6);
        base_a = cnt_a; base_b = cnt_b;
        adv_sec(10);
        check("R7 exact alarm once", 32'(cnt_a - base_a), 32'd1);
        check("R7 seconds-only alarm once", 32'(cnt_b - base_b), 32'd1);
        write_reg(SEL_ALM_B_C, {1'b1, 1'b0, 6'h00, 1'b1, 1'b0, 6'h00, 1'b1, 7'h00, 1'b1, 7'h00});
        base_b = cnt_b;
        adv_sec(4);
        check("R7 fully masked every second", 32'(cnt_b - base_b), 32'd4);
        write_reg(SEL_CTRL_C, 32'h0);
        base_b = cnt_b;
        adv_sec(3);
        check("R7 disabled alarm silent", 32'(cnt_b - base_b), 32'd0);
        write_reg(SEL_ALM_A_C, {1'b0, 1'b1, 6'h01, 1'b1, 1'b0, 6'h00, 1'b1, 7'h00, 1'b1, 7'h00});
        write_reg(SEL_CTRL_C, 32'h2);
        base_a = cnt_a;
        adv_sec(2);
        check("R7 weekday match", 32'(cnt_a - base_a), 32'd2);
        write_reg(SEL_ALM_A_C, {1'b0, 1'b1, 6'h02, 1'b1, 1'b0, 6'h00, 1'b1, 7'h00, 1'b1, 7'h00});
        base_a = cnt_a;
        adv_sec(2);
        check("R7 weekday mismatch", 32'(cnt_a - base_a), 32'd0);
        write_reg(SEL_CTRL_C, 32'h0);

        // R8: wakeup periods
        write_reg(SEL_WAKE_C, (32'd1 << WAKE_W) | 32'd4);
        base_w = cnt_w;
        for (int i = 0; i < 20; i++) tick_once();
        check("R8 period reload+1", 32'(cnt_w - base_w), 32'd4);
        write_reg(SEL_WAKE_C, (32'd1 << WAKE_W));
        base_w = cnt_w;
        for (int i = 0; i < 3; i++) tick_once();
        check("R8 reload zero every tick", 32'(cnt_w - base_w), 32'd3);
        write_reg(SEL_WAKE_C, 32'd0);
        base_w = cnt_w;
        for (int i = 0; i < 5; i++) tick_once();
        check("R8 disabled silent", 32'(cnt_w - base_w), 32'd0);

        // R9: timestamp capture and hold
        write_reg(SEL_TIME_C, tword(8, 30, 15, 0));
        write_reg(SEL_DATE_C, dword(9, 3, 25, 5));
        tick_once();
        @(negedge clk);
        ts_in = 1'b1;
        @(negedge clk);
        ts_in = 1'b0;
        check("R9 captured time", ts_time, tword(8, 30, 15, 0));
        check("R9 captured date", ts_date, dword(9, 3, 25, 5));
        check("R9 captured subsec", 32'(ts_subsec), 32'd1);
        adv_sec(1);
        check("R9 time moved on", cur_time, tword(8, 30, 16, 0));
        check("R9 capture held", ts_time, tword(8, 30, 15, 0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    localparam logic [2:0] SEL_TIME_C  = 3'd0;
    localparam logic [2:0] SEL_DATE_C  = 3'd1;
    localparam logic [2:0] SEL_ALM_A_C = 3'd2;
    localparam logic [2:0] SEL_ALM_B_C = 3'd3;
    localparam logic [2:0] SEL_WAKE_C  = 3'd4;
    localparam logic [2:0] SEL_CTRL_C  = 3'd5;

endmodule